// File: doc/BRIEF.md
# Split-Key Memoizing Associative Lookup

This block is an associative lookup array of a fixed number of entries. Each entry holds a search key and a data payload, the kind of structure found in a translation buffer or a load/store queue. A search presents a full key. One clock later the block returns a hit flag, the index of the matching entry and that entry's payload. Entries are loaded through a simple write port that names the slot to fill.

Each key is split into an upper field and a lower field, and each field has its own comparator in every entry. The upper field tends to repeat from one search to the next. The block keeps the upper field of the last search that compared it. While the upper field of a new search equals that stored value, the upper comparators stay idle and are not driven. Each entry then reuses a flip-flop that holds its last upper-field result. Any write discards the stored upper value, so the following search always compares afresh. A status output marks every result whose search drove the upper comparators, which shows how many comparisons were skipped.

Top module: `memo_cam`

## Requirements
- R1: After reset, `hit`, `hitIdx`, `hitData` and `driveUpper` are all 0, and no entry is valid.
- R2: A search with `srchEn`=1 returns its result on the next clock edge. `hit`=1 if a valid entry's stored key equals `srchKey` in every bit; `hitIdx` is then that entry's slot and `hitData` its payload. When nothing matches, `hit`=0 and `hitIdx`/`hitData` are 0.
- R3: When several valid entries match, the lowest slot index is reported.
- R4: The first search after reset drives the upper comparators: `driveUpper`=1 with its result.
- R5: A search whose upper field (`srchKey[KEY_W-1:LOW_W]`) equals that of the last upper-driving search, with no write in between, does not drive the upper comparators (`driveUpper`=0). Its result is still the same as R2 requires, for hits and for misses.
- R6: A search whose upper field differs from the stored one drives the upper comparators (`driveUpper`=1) and becomes the new stored upper value.
- R7: A write with `wrEn`=1 stores `wrKey`/`wrData` into slot `wrIdx` and marks the slot valid. The next search drives the upper comparators even when its upper field repeats, and it sees the new contents.
- R8: In a cycle with `srchEn`=0, `hit` and `driveUpper` are 0 on the next edge. Idle cycles do not clear the stored upper value.
- R9: An entry whose lower field equals the search's lower field but whose upper field differs does not match.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rstN | input | 1 | Asynchronous reset, active low |
| wrEn | input | 1 | Write the entry named by wrIdx |
| wrIdx | input | IDX_W | Slot to write |
| wrKey | input | KEY_W | Key to store |
| wrData | input | DATA_W | Payload to store |
| srchEn | input | 1 | Start a search this cycle |
| srchKey | input | KEY_W | Search key; upper field is bits KEY_W-1:LOW_W |
| hit | output | 1 | A valid entry matched (registered) |
| hitIdx | output | IDX_W | Lowest matching slot |
| hitData | output | DATA_W | Payload of that slot |
| driveUpper | output | 1 | The reported search drove the upper comparators |

## Verification
Every result (`hit`, `hitIdx`, `hitData`, `driveUpper`) is due on the first rising edge after the cycle in which the search or idle stimulus is held. A write takes effect on the edge that samples it. The bench applies each stimulus on a falling edge, holds it through exactly one rising edge, and compares the outputs on the next falling edge, against a reference model of entries and stored upper field that is updated in the same order. The idle check samples one falling edge later, after a rising edge that saw `srchEn` low.

// File: rtl/memo_cam_pkg.sv
package memo_cam_pkg;
  // Strobes from control to datapath for one cycle.
  typedef struct packed {
    logic lookup;  // a search is presented this cycle
    logic fresh;   // upper field must be broadcast and compared
  } camStrobes_t;
endpackage

// File: rtl/memo_cam_ctrl.sv
module memo_cam_ctrl
  import memo_cam_pkg::*;
#(
  parameter int HIGH_W = 28
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              srchEn,
  input  logic              wrEn,
  input  logic [HIGH_W-1:0] srchHigh,
  output camStrobes_t       strobes,
  output logic              driveUpper
);
  logic [HIGH_W-1:0] prevHighQ;
  logic              prevValidQ;
  logic              repeatHigh;

  assign repeatHigh     = prevValidQ && (srchHigh == prevHighQ);
  assign strobes.lookup = srchEn;
  assign strobes.fresh  = srchEn && !repeatHigh;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      prevHighQ  <= '0;
      prevValidQ <= 1'b0;
      driveUpper <= 1'b0;
    end else begin
      driveUpper <= strobes.fresh;
      if (wrEn) begin
        prevValidQ <= 1'b0;          // contents changed: memo is stale
      end else if (strobes.fresh) begin
        prevValidQ <= 1'b1;
        prevHighQ  <= srchHigh;
      end
    end
  end
endmodule

// File: rtl/memo_cam_dp.sv
module memo_cam_dp
  import memo_cam_pkg::*;
#(
  parameter int ENTRIES = 8,
  parameter int KEY_W   = 40,
  parameter int LOW_W   = 12,
  parameter int DATA_W  = 16,
  localparam int HIGH_W = KEY_W - LOW_W,
  localparam int IDX_W  = (ENTRIES > 1) ? $clog2(ENTRIES) : 1
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              wrEn,
  input  logic [IDX_W-1:0]  wrIdx,
  input  logic [KEY_W-1:0]  wrKey,
  input  logic [DATA_W-1:0] wrData,
  input  logic [KEY_W-1:0]  srchKey,
  input  camStrobes_t       strobes,
  output logic              hit,
  output logic [IDX_W-1:0]  hitIdx,
  output logic [DATA_W-1:0] hitData
);
  logic [HIGH_W-1:0] keyHighQ [ENTRIES];
  logic [LOW_W-1:0]  keyLowQ  [ENTRIES];
  logic [DATA_W-1:0] dataQ    [ENTRIES];
  logic [ENTRIES-1:0] validQ, hMatchQ, highEq, hUse, lowEq, match;

  logic [HIGH_W-1:0] srchHigh;
  logic [LOW_W-1:0]  srchLow;
  logic              anyHit;
  logic [IDX_W-1:0]  selIdx;
  logic [DATA_W-1:0] selData;

  assign srchHigh = srchKey[KEY_W-1:LOW_W];
  assign srchLow  = srchKey[LOW_W-1:0];

  for (genvar i = 0; i < ENTRIES; i++) begin : gEntry
    // upper comparator is gated off unless a fresh broadcast happens
    assign highEq[i] = strobes.fresh && validQ[i] && (keyHighQ[i] == srchHigh);
    assign hUse[i]   = strobes.fresh ? highEq[i] : hMatchQ[i];
    assign lowEq[i]  = validQ[i] && (keyLowQ[i] == srchLow);
    assign match[i]  = strobes.lookup && hUse[i] && lowEq[i];

    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        validQ[i]   <= 1'b0;
        hMatchQ[i]  <= 1'b0;
        keyHighQ[i] <= '0;
        keyLowQ[i]  <= '0;
        dataQ[i]    <= '0;
      end else begin
        if (strobes.fresh) hMatchQ[i] <= highEq[i];
        if (wrEn && (wrIdx == IDX_W'(i))) begin
          validQ[i]   <= 1'b1;
          keyHighQ[i] <= wrKey[KEY_W-1:LOW_W];
          keyLowQ[i]  <= wrKey[LOW_W-1:0];
          dataQ[i]    <= wrData;
        end
      end
    end
  end

  // priority encoder: lowest index wins
  always_comb begin
    anyHit = 1'b0;
    selIdx = '0;
    for (int i = ENTRIES - 1; i >= 0; i--) begin
      if (match[i]) begin
        anyHit = 1'b1;
        selIdx = IDX_W'(i);
      end
    end
    selData = anyHit ? dataQ[selIdx] : '0;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      hit     <= 1'b0;
      hitIdx  <= '0;
      hitData <= '0;
    end else begin
      hit     <= anyHit;
      hitIdx  <= selIdx;
      hitData <= selData;
    end
  end
endmodule

// File: rtl/memo_cam.sv
module memo_cam
  import memo_cam_pkg::*;
#(
  parameter int ENTRIES = 8,
  parameter int KEY_W   = 40,
  parameter int LOW_W   = 12,
  parameter int DATA_W  = 16,
  localparam int HIGH_W = KEY_W - LOW_W,
  localparam int IDX_W  = (ENTRIES > 1) ? $clog2(ENTRIES) : 1
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              wrEn,
  input  logic [IDX_W-1:0]  wrIdx,
  input  logic [KEY_W-1:0]  wrKey,
  input  logic [DATA_W-1:0] wrData,
  input  logic              srchEn,
  input  logic [KEY_W-1:0]  srchKey,
  output logic              hit,
  output logic [IDX_W-1:0]  hitIdx,
  output logic [DATA_W-1:0] hitData,
  output logic              driveUpper
);
  camStrobes_t strobes;

  memo_cam_ctrl #(.HIGH_W(HIGH_W)) u_ctrl (
    .clk(clk), .rstN(rstN), .srchEn(srchEn), .wrEn(wrEn),
    .srchHigh(srchKey[KEY_W-1:LOW_W]), .strobes(strobes),
    .driveUpper(driveUpper)
  );

  memo_cam_dp #(.ENTRIES(ENTRIES), .KEY_W(KEY_W), .LOW_W(LOW_W), .DATA_W(DATA_W)) u_dp (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .wrIdx(wrIdx), .wrKey(wrKey),
    .wrData(wrData), .srchKey(srchKey), .strobes(strobes),
    .hit(hit), .hitIdx(hitIdx), .hitData(hitData)
  );
endmodule

// File: rtl/memo_cam_checker.sv
module memo_cam_checker #(
  parameter int KEY_W = 40,
  parameter int LOW_W = 12
) (
  input logic             clk,
  input logic             rstN,
  input logic             wrEn,
  input logic             srchEn,
  input logic [KEY_W-1:0] srchKey,
  input logic             hit,
  input logic             driveUpper
);
  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rstN)
    !srchEn |=> (!hit && !driveUpper)); // R8

  AST_DRIVE_NEEDS_SEARCH: assert property (@(posedge clk) disable iff (!rstN)
    driveUpper |-> $past(srchEn)); // R6

  AST_WRITE_FORCES_DRIVE: assert property (@(posedge clk) disable iff (!rstN)
    (srchEn && $past(wrEn)) |=> driveUpper); // R7

  AST_REPEAT_SKIPS: assert property (@(posedge clk) disable iff (!rstN)
    (srchEn && $past(srchEn) && !$past(wrEn) && !wrEn &&
     srchKey[KEY_W-1:LOW_W] == $past(srchKey[KEY_W-1:LOW_W])) |=> !driveUpper); // R5
endmodule

bind memo_cam memo_cam_checker #(.KEY_W(KEY_W), .LOW_W(LOW_W)) u_checker (
  .clk(clk), .rstN(rstN), .wrEn(wrEn), .srchEn(srchEn),
  .srchKey(srchKey), .hit(hit), .driveUpper(driveUpper)
);

// File: tb/memo_cam_bench.sv
module memo_cam_bench;
  localparam int ENTRIES = 8, KEY_W = 40, LOW_W = 12, DATA_W = 16;
  localparam int HIGH_W = KEY_W - LOW_W, IDX_W = $clog2(ENTRIES);

  logic clk = 1'b0, rstN = 1'b0;
  logic wrEn = 1'b0, srchEn = 1'b0;
  logic [IDX_W-1:0] wrIdx = '0;
  logic [KEY_W-1:0] wrKey = '0, srchKey = '0;
  logic [DATA_W-1:0] wrData = '0;
  logic hit, driveUpper;
  logic [IDX_W-1:0] hitIdx;
  logic [DATA_W-1:0] hitData;

  int testCnt = 0, failCnt = 0;

  // reference model
  logic [KEY_W-1:0]  mKey [ENTRIES];
  logic [DATA_W-1:0] mData [ENTRIES];
  logic [ENTRIES-1:0] mValid = '0;
  logic [HIGH_W-1:0] mPrevHigh = '0;
  logic mPrevValid = 1'b0;

  memo_cam u_memo_cam (.*);

  always #10 clk = ~clk;

  initial begin
    for (int c = 0; c < 20000; c++) @(posedge clk);
    failCnt++;
    $display("FAIL watchdog: actual=hung expected=finished");
    $display("  [TB] %0d tests run, %0d failed", testCnt, failCnt);
    $finish;
  end

  function automatic logic [KEY_W-1:0] mk(input logic [HIGH_W-1:0] h, input logic [LOW_W-1:0] l);
    return {h, l};
  endfunction

  task automatic check(input logic ok, input string tag, input longint act, input longint exp);
    testCnt++;
    if (!ok) begin
      failCnt++;
      $display("FAIL %s: actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic doWrite(input int idx, input logic [KEY_W-1:0] k, input logic [DATA_W-1:0] d);
    @(negedge clk);
    wrEn = 1'b1; wrIdx = IDX_W'(idx); wrKey = k; wrData = d;
    @(negedge clk);
    wrEn = 1'b0;
    mKey[idx] = k; mData[idx] = d; mValid[idx] = 1'b1; mPrevValid = 1'b0;
  endtask

  task automatic doSearch(input logic [KEY_W-1:0] k, input string tag);
    logic expHit = 1'b0, expDrive;
    logic [IDX_W-1:0] expIdx = '0;
    logic [DATA_W-1:0] expData = '0;
    for (int i = ENTRIES - 1; i >= 0; i--)
      if (mValid[i] && mKey[i] == k) begin expHit = 1'b1; expIdx = IDX_W'(i); expData = mData[i]; end
    expDrive = !(mPrevValid && k[KEY_W-1:LOW_W] == mPrevHigh);
    if (expDrive) begin mPrevValid = 1'b1; mPrevHigh = k[KEY_W-1:LOW_W]; end
    @(negedge clk);
    srchEn = 1'b1; srchKey = k;
    @(negedge clk);
    srchEn = 1'b0;
    check(hit == expHit, {tag, " hit"}, hit, expHit);
    check(hitIdx == expIdx, {tag, " hitIdx"}, hitIdx, expIdx);
    check(hitData == expData, {tag, " hitData"}, hitData, expData);
    check(driveUpper == expDrive, {tag, " driveUpper"}, driveUpper, expDrive);
  endtask

  task automatic testReset();
    check(hit == 1'b0, "R1 hit", hit, 0);
    check(hitIdx == '0, "R1 hitIdx", hitIdx, 0);
    check(hitData == '0, "R1 hitData", hitData, 0);
    check(driveUpper == 1'b0, "R1 driveUpper", driveUpper, 0);
  endtask

  task automatic testLoadAndSearch();
    doWrite(0, mk(28'h1, 12'h011), 16'hA000);
    doWrite(1, mk(28'h1, 12'h022), 16'hA001);
    doWrite(2, mk(28'h2, 12'h011), 16'hA002);
    doWrite(3, mk(28'h1, 12'h022), 16'hA003);
    doWrite(5, mk(28'h3, 12'h055), 16'hA005);
    doSearch(mk(28'h1, 12'h011), "R2_R4 first search");
  endtask

  task automatic testMemo();
    doSearch(mk(28'h1, 12'h022), "R3_R5 repeat high, duplicate key");
    doSearch(mk(28'h1, 12'h099), "R5 repeat high miss");
    doSearch(mk(28'h2, 12'h011), "R6_R9 new high same low");
    doSearch(mk(28'h4, 12'h011), "R9 unmatched high");
  endtask

  task automatic testIdle();
    @(negedge clk);
    check(hit == 1'b0, "R8 idle hit", hit, 0);
    check(driveUpper == 1'b0, "R8 idle driveUpper", driveUpper, 0);
    doSearch(mk(28'h4, 12'h011), "R8 high kept over idle");
  endtask

  task automatic testWriteInvalidates();
    doWrite(6, mk(28'h4, 12'h077), 16'hA006);
    doSearch(mk(28'h4, 12'h077), "R7 write then same high");
    doWrite(0, mk(28'h5, 12'h011), 16'hB000);
    doSearch(mk(28'h1, 12'h011), "R7 overwritten key gone");
    doSearch(mk(28'h5, 12'h011), "R7 new key found");
    doSearch(mk(28'h1, 12'h022), "R3 lowest of two after rewrite");
  endtask

  initial begin
    repeat (3) @(negedge clk);
    testReset();
    rstN = 1'b1;
    testLoadAndSearch();
    testMemo();
    testIdle();
    testWriteInvalidates();
    repeat (2) @(negedge clk);
    $display("  [TB] %0d tests run, %0d failed", testCnt, failCnt);
    $finish;
  end
endmodule